// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block acts as the station-management master for one external Ethernet PHY. It runs IEEE clause-22 read and write frames over a two-wire management link: a clock line (MDC) that the block derives from the system clock, and a bidirectional data line (MDIO). The data line appears here as separate output, output-enable and input pins. A pad cell outside the block ties these three together.

Software sees two 32-bit registers through a simple write-strobe and select port. Register 0 (control) holds the enable, the divider and an idle flag. Register 1 (access) holds the transaction fields. To run a transaction, software writes register 1 with the start flag set, then polls until the flag drops. After that it reads the returned data and the acknowledge flag from the same register. One frame is 64 MDC periods long: a 32-bit preamble of ones, a start pattern, an opcode, two 5-bit addresses, a 2-bit turnaround and a 16-bit data field. The block changes MDIO only on falling MDC edges and samples it only on rising edges.

Top module: `mdio_master`

## Requirements
- R1: After reset, control reads 0x800000FF (idle set, disabled, divider 0xFF), access reads 0, MDC is low, MDIO output enable is low and MDIO output is high.
- R2: Control bits 15:0 hold the divider D. While the clock runs, MDC has a period of D+1 system clocks: low for floor((D+1)/2) clocks, then high for the rest. A divider of 0 behaves like 1.
- R3: Access bit 31 is the start flag. Writing it as 1 while control bit 30 (enable) is 1 starts a frame at the next falling MDC edge. The flag reads 1 until the frame's 64th bit period ends, and then clears on its own.
- R4: Every frame sends 32 ones, then start bits 0,1, then the opcode (1,0 when access bit 30 is 0 for a read; 0,1 when it is 1 for a write), then the PHY address in bits 20:16 and the register address in bits 25:21, each 5 bits with the most significant bit first.
- R5: A write frame drives turnaround as 1 then 0, then sends access bits 15:0 with the most significant bit first. Output enable stays high for all 64 bit periods. At completion, access bit 29 (acknowledge) reads 0 and the data field keeps its written value.
- R6: A read frame releases MDIO (output enable low) from the first turnaround bit to the end of the frame. It samples MDIO on the rising edge in the second turnaround bit; a low level sets acknowledge. The 16 rising-edge samples that follow fill access bits 15:0, most significant bit first.
- R7: A read frame whose second turnaround sample is high finishes with acknowledge at 0 and access bits 15:0 at 0xFFFF.
- R8: MDIO output and output enable change only on the system clock edge where MDC falls.
- R9: A write to the access register while its start flag reads 1 has no effect on any field.
- R10: MDC stays low whenever the block is disabled and no frame is running. Clearing the enable during a frame lets that frame finish first. A start flag set while disabled stays pending and launches once the enable is set.
- R11: Control bit 31 reads 1 exactly when no frame is in progress. Between frames, output enable is low and MDIO output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
A bad divider count or a bad edge decision shows up at the MDC pin within one MDC period. A bit counter that is off by one position moves the start, opcode or address bits on MDIO inside the same frame, and it also moves the edge where the output enable drops. Errors in the sampling path stay hidden until the start flag clears. Then they appear in the access register as wrong data or a wrong acknowledge, at most 64 MDC periods later. Comparing the pins and both registers every cycle against an independent model catches each of these at the first cycle where it becomes visible.

// File: rtl/mdio_pkg.sv
// Package: shared field positions and the request record for the MDIO master.
// Assumes a 32-bit register word and clause-22 framing (16 data bits, 5-bit addresses).
package mdio_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int WORD_W   = 32;

    // Access register bit positions that software decodes
    localparam int ACC_GO   = 31;
    localparam int ACC_WR   = 30;
    localparam int ACC_ACK  = 29;
    localparam int ACC_REG  = 21;
    localparam int ACC_PHY  = 16;

    // Control register bit positions
    localparam int CTL_IDLE = 31;
    localparam int CTL_EN   = 30;

    // Transaction fields held while a frame runs
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } mdio_req_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: MDC generator.
// Divides clk by (div+1) while run is high; a divider of 0 is treated as 1.
// fall_evt/rise_evt mark the clk cycle whose edge makes mdc fall/rise.
// Assumes div is not changed in the middle of a frame.
module mdio_mdc_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             fall_evt,
    output logic             rise_evt
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W:0]   half;

    // Clamp divider and find the low-phase length
    always_comb begin
        div_eff  = (div == '0) ? DIV_W'(1) : div;
        half     = ({1'b0, div_eff} + (DIV_W+1)'(1)) >> 1;
        fall_evt = run && (cnt_q >= div_eff);
        rise_evt = run && !fall_evt && ({1'b0, cnt_q} == half - (DIV_W+1)'(1));
    end

    // Period counter and registered MDC level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run || fall_evt) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
            if (rise_evt) begin
                mdc <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdio_bit_map.sv
// Module: frame bit map.
// For a bit index within one frame, gives the level to drive, whether the
// master drives at all, and whether the index is an ack or data sample slot.
// Assumes idx < PRE_LEN + 32.
module mdio_bit_map
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int IDX_W   = 7
) (
    input  logic [IDX_W-1:0] idx,
    input  mdio_req_t        req,
    output logic             drv,
    output logic             drv_en,
    output logic             smp_ack,
    output logic             smp_dat
);

    localparam int HDR_AT = PRE_LEN;
    localparam int TA_AT  = PRE_LEN + 14;
    localparam int DAT_AT = PRE_LEN + 16;

    logic [31:0] hdr;
    logic [4:0]  rel;
    logic        raw;

    // Decode the bit at idx from the post-preamble word
    always_comb begin
        hdr     = {2'b01, (req.wr ? 2'b01 : 2'b10), req.phy, req.regad, 2'b10, req.data};
        rel     = 5'(idx - IDX_W'(HDR_AT));
        raw     = (idx < IDX_W'(HDR_AT)) ? 1'b1 : hdr[~rel];
        drv_en  = req.wr || (idx < IDX_W'(TA_AT));
        drv     = drv_en ? raw : 1'b1;
        smp_ack = !req.wr && (idx == IDX_W'(TA_AT + 1));
        smp_dat = !req.wr && (idx >= IDX_W'(DAT_AT));
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
// Module: frame engine.
// Starts a frame on a falling MDC event when go and en are set, advances one
// bit per falling event, and samples MDIO on rising events during reads.
// done pulses combinationally on the event that closes the last bit.
// Assumes req is held stable by the register file while busy.
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              go,
    input  mdio_req_t         req,
    input  logic              fall_evt,
    input  logic              rise_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              res_ack,
    output logic [DATA_W-1:0] res_data
);

    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN + 1);
    localparam int LAST      = FRAME_LEN - 1;

    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_nx;
    logic              ack_q;
    logic [DATA_W-1:0] sh_q;
    logic              nx_drv, nx_en;
    logic              cur_ack, cur_dat;
    logic              nx_ack_unused, nx_dat_unused;
    logic              cur_drv_unused, cur_en_unused;

    // Index of the bit driven after the next falling event
    always_comb begin
        idx_nx = busy ? (idx_q + IDX_W'(1)) : '0;
        done   = fall_evt && busy && (idx_q == IDX_W'(LAST));
    end

    mdio_bit_map #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W)) u_map_nx (
        .idx     (idx_nx),
        .req     (req),
        .drv     (nx_drv),
        .drv_en  (nx_en),
        .smp_ack (nx_ack_unused),
        .smp_dat (nx_dat_unused)
    );

    mdio_bit_map #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W)) u_map_cur (
        .idx     (idx_q),
        .req     (req),
        .drv     (cur_drv_unused),
        .drv_en  (cur_en_unused),
        .smp_ack (cur_ack),
        .smp_dat (cur_dat)
    );

    // Frame sequencing on falling events, sampling on rising events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx_q   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            ack_q   <= 1'b0;
            sh_q    <= '0;
        end else if (fall_evt) begin
            if (busy) begin
                if (idx_q == IDX_W'(LAST)) begin
                    busy    <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    idx_q   <= idx_nx;
                    mdio_o  <= nx_drv;
                    mdio_oe <= nx_en;
                end
            end else if (go && en) begin
                busy    <= 1'b1;
                idx_q   <= idx_nx;
                mdio_o  <= nx_drv;
                mdio_oe <= nx_en;
                ack_q   <= 1'b0;
            end
        end else if (rise_evt && busy) begin
            if (cur_ack) begin
                ack_q <= ~mdio_i;
            end
            if (cur_dat) begin
                sh_q <= {sh_q[DATA_W-2:0], mdio_i};
            end
        end
    end

    // Result presented to the register file at completion
    always_comb begin
        res_ack  = ack_q;
        res_data = ack_q ? sh_q : '1;
    end

endmodule

// File: rtl/mdio_csr.sv
// Module: register file.
// Holds control (enable, divider) and access (start flag, fields, ack, data).
// Access writes are dropped while the start flag is set; done clears the flag
// and loads the read result. Assumes DIV_W <= 16.
module mdio_csr
    import mdio_pkg::*;
#(
    parameter int          DIV_W   = 16,
    parameter int unsigned DIV_RST = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              res_ack,
    input  logic [DATA_W-1:0] res_data,
    output logic              ctl_en,
    output logic [DIV_W-1:0]  ctl_div,
    output logic              acc_go,
    output mdio_req_t         acc_req
);

    logic              acc_ack;
    logic [WORD_W-1:0] ctl_word;
    logic [WORD_W-1:0] acc_word;
    logic              wd_unused;

    assign wd_unused = ^reg_wdata;

    // Register updates from software and from frame completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en  <= 1'b0;
            ctl_div <= DIV_W'(DIV_RST);
            acc_go  <= 1'b0;
            acc_ack <= 1'b0;
            acc_req <= '0;
        end else begin
            if (done) begin
                acc_go <= 1'b0;
                if (acc_req.wr) begin
                    acc_ack <= 1'b0;
                end else begin
                    acc_ack      <= res_ack;
                    acc_req.data <= res_data;
                end
            end
            if (reg_we && !reg_sel) begin
                ctl_en  <= reg_wdata[CTL_EN];
                ctl_div <= reg_wdata[DIV_W-1:0];
            end
            if (reg_we && reg_sel && !acc_go) begin
                acc_go        <= reg_wdata[ACC_GO];
                acc_req.wr    <= reg_wdata[ACC_WR];
                acc_req.regad <= reg_wdata[ACC_REG +: ADDR_W];
                acc_req.phy   <= reg_wdata[ACC_PHY +: ADDR_W];
                acc_req.data  <= reg_wdata[DATA_W-1:0];
            end
        end
    end

    // Read view of both registers
    always_comb begin
        ctl_word                 = '0;
        ctl_word[CTL_IDLE]       = ~busy;
        ctl_word[CTL_EN]         = ctl_en;
        ctl_word[DIV_W-1:0]      = ctl_div;
        acc_word                 = '0;
        acc_word[ACC_GO]         = acc_go;
        acc_word[ACC_WR]         = acc_req.wr;
        acc_word[ACC_ACK]        = acc_ack;
        acc_word[ACC_REG +: ADDR_W] = acc_req.regad;
        acc_word[ACC_PHY +: ADDR_W] = acc_req.phy;
        acc_word[DATA_W-1:0]     = acc_req.data;
        reg_rdata                = reg_sel ? acc_word : ctl_word;
    end

endmodule

// File: rtl/mdio_master.sv
// Module: MDIO management master, top level.
// Ties the register file, MDC generator and frame engine together.
// MDC runs while enabled or while a frame is still in progress.
// Assumes an external pad combines mdio_o/mdio_oe/mdio_i.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int          DIV_W   = 16,
    parameter int unsigned DIV_RST = 255,
    parameter int          PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic              ctrl_en;
    logic [DIV_W-1:0]  ctrl_div;
    logic              acc_go;
    mdio_req_t         acc_req;
    logic              fr_busy;
    logic              fr_done;
    logic              res_ack;
    logic [DATA_W-1:0] res_data;
    logic              fall_evt;
    logic              rise_evt;
    logic              mdc_run;

    // Clock keeps running until an in-flight frame closes
    assign mdc_run = ctrl_en || fr_busy;

    mdio_csr #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (fr_busy),
        .done      (fr_done),
        .res_ack   (res_ack),
        .res_data  (res_data),
        .ctl_en    (ctrl_en),
        .ctl_div   (ctrl_div),
        .acc_go    (acc_go),
        .acc_req   (acc_req)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mdc_run),
        .div      (ctrl_div),
        .mdc      (mdc),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt)
    );

    mdio_frame_fsm #(.PRE_LEN(PRE_LEN)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_en),
        .go       (acc_go),
        .req      (acc_req),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt),
        .mdio_i   (mdio_i),
        .busy     (fr_busy),
        .done     (fr_done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .res_ack  (res_ack),
        .res_data (res_data)
    );

endmodule

// File: rtl/mdio_master_chk.sv
// Module: property checker for mdio_master, attached by bind below.
// Observes pins plus enable, busy, start flag and request fields.
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      mdc,
    input logic      mdio_o,
    input logic      mdio_oe,
    input logic      en,
    input logic      busy,
    input logic      go,
    input mdio_req_t req
);

    // R8: data level moves only with a falling MDC
    a_r8_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    // R8: output enable moves only with a falling MDC
    a_r8_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $fell(mdc));

    // R10: MDC parked low when disabled and idle
    a_r10_mdc_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && !$past(busy)) |-> !mdc);

    // R3: start flag stays set for the whole frame
    a_r3_go_covers_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> go);

    // R11: line released and high between frames
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && mdio_o));

    // R6: once a read releases the line it stays released
    a_r6_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req.wr && !mdio_oe) |=> (!mdio_oe || !busy));

    // R9: fields frozen while the start flag is held
    a_r9_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (go && $past(go)) |-> $stable(req));

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .en      (ctrl_en),
    .busy    (fr_busy),
    .go      (acc_go),
    .req     (acc_req)
);

// File: tb/tb_mdio_master.sv
// Bench: behavioural cycle model of the MDIO master plus a simple PHY,
// compared against the design at every clock.
module tb_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit track = 0;

    // PHY behaviour knobs
    bit          phy_here = 1;
    logic [15:0] phy_resp = '0;

    always #10 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- reference model state ----------------
    int m_en, m_div, m_cnt, m_mdc, m_act, m_k, m_go, m_wr, m_phy, m_reg;
    int m_data, m_ack, m_sh, m_seen, m_o, m_oe;
    int deff, half, run, fall, rise, done, go_old, fn;
    bit fo[64];
    bit foe[64];

    task automatic push(input bit o, input bit oe);
        fo[fn] = o; foe[fn] = oe; fn++;
    endtask

    task automatic build_frame();
        fn = 0;
        for (int i = 0; i < 32; i++) push(1, 1);
        push(0, 1); push(1, 1);
        if (m_wr != 0) begin push(0, 1); push(1, 1); end
        else begin push(1, 1); push(0, 1); end
        for (int i = 4; i >= 0; i--) push(bit'((m_phy >> i) & 1), 1);
        for (int i = 4; i >= 0; i--) push(bit'((m_reg >> i) & 1), 1);
        if (m_wr != 0) begin
            push(1, 1); push(0, 1);
            for (int i = 15; i >= 0; i--) push(bit'((m_data >> i) & 1), 1);
        end else begin
            for (int i = 0; i < 18; i++) push(1, 0);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_div = 255; m_cnt = 0; m_mdc = 0; m_act = 0; m_k = 0;
            m_go = 0; m_wr = 0; m_phy = 0; m_reg = 0; m_data = 0; m_ack = 0;
            m_sh = 0; m_seen = 0; m_o = 1; m_oe = 0;
        end else begin
            deff = (m_div == 0) ? 1 : m_div;
            half = (deff + 1) / 2;
            run  = (m_en != 0 || m_act != 0) ? 1 : 0;
            fall = (run != 0 && m_cnt >= deff) ? 1 : 0;
            rise = (run != 0 && fall == 0 && m_cnt == half - 1) ? 1 : 0;
            done = 0;
            go_old = m_go;
            if (run == 0 || fall != 0) begin m_cnt = 0; m_mdc = 0; end
            else begin m_cnt++; if (rise != 0) m_mdc = 1; end
            if (fall != 0) begin
                if (m_act != 0) begin
                    if (m_k == 63) begin m_act = 0; m_oe = 0; m_o = 1; done = 1; end
                    else begin m_k++; m_o = fo[m_k]; m_oe = foe[m_k]; end
                end else if (m_go != 0 && m_en != 0) begin
                    build_frame();
                    m_act = 1; m_k = 0; m_o = fo[0]; m_oe = foe[0]; m_seen = 0;
                end
            end else if (rise != 0 && m_act != 0 && m_wr == 0) begin
                if (m_k == 47) m_seen = (mdio_i == 1'b0) ? 1 : 0;
                else if (m_k >= 48) m_sh = ((m_sh << 1) | int'(mdio_i)) & 16'hFFFF;
            end
            if (done != 0) begin
                m_go = 0;
                if (m_wr != 0) m_ack = 0;
                else begin m_ack = m_seen; m_data = (m_seen != 0) ? m_sh : 16'hFFFF; end
            end
            if (reg_we) begin
                if (!reg_sel) begin
                    m_en = int'(reg_wdata[30]); m_div = int'(reg_wdata[15:0]);
                end else if (go_old == 0) begin
                    m_go = int'(reg_wdata[31]); m_wr = int'(reg_wdata[30]);
                    m_reg = int'(reg_wdata[25:21]); m_phy = int'(reg_wdata[20:16]);
                    m_data = int'(reg_wdata[15:0]);
                end
            end
        end
    end

    function automatic logic [31:0] exp_word(input logic s);
        if (s) return (32'(m_go) << 31) | (32'(m_wr) << 30) | (32'(m_ack) << 29) |
                      (32'(m_reg) << 21) | (32'(m_phy) << 16) | 32'(m_data);
        return ((m_act == 0) ? 32'h8000_0000 : 32'h0) | (32'(m_en) << 30) | 32'(m_div);
    endfunction

    // Per-cycle comparison away from the edge, then PHY drives the line
    always @(negedge clk) begin
        #5;
        if (track) begin
            chk("R2 mdc", 32'(mdc), 32'(m_mdc));
            chk("R8 mdio_oe", 32'(mdio_oe), 32'(m_oe));
            chk("R4 mdio_o", 32'(mdio_o), 32'(m_o));
            chk("R3 reg_rdata", reg_rdata, exp_word(reg_sel));
        end
        if (m_act != 0 && m_wr == 0 && phy_here && m_k >= 47)
            mdio_i = (m_k == 47) ? 1'b0 : phy_resp[15 - (m_k - 48)];
        else
            mdio_i = 1'b1;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic poke(input logic s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic peek(input logic s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #7;
        v = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        v = 32'h8000_0000;
        while (v[31]) peek(1'b1, v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        peek(1'b0, v); chk("R1 control", v, 32'h8000_00FF);
        peek(1'b1, v); chk("R1 access", v, 32'h0);
        chk("R1 mdc", 32'(mdc), 32'h0);
        chk("R1 oe/o", {30'b0, mdio_oe, mdio_o}, 32'h1);
        track = 1;

        // R6: acknowledged read, with an ignored write while busy (R9)
        poke(1'b0, 32'h4000_0003);
        phy_here = 1; phy_resp = 16'hA5C3;
        poke(1'b1, 32'h8045_0000);
        poke(1'b1, 32'hC0FF_1234);
        idle(10);
        peek(1'b0, v); chk("R11 idle low in frame", v, 32'h4000_0003);
        wait_done();
        peek(1'b1, v); chk("R6 read result", v, 32'h2045_A5C3);
        chk("R9 fields kept", v & 32'h43FF_0000, 32'h0045_0000);

        // R5: write frame, even-length period
        poke(1'b0, 32'h4000_0004);
        poke(1'b1, 32'hC01F_3C5A);
        wait_done();
        peek(1'b1, v); chk("R5 write result", v, 32'h401F_3C5A);

        // R7: read with no PHY answering
        phy_here = 0;
        poke(1'b1, 32'h83E0_0000);
        wait_done();
        peek(1'b1, v); chk("R7 no-ack result", v, 32'h03E0_FFFF);

        // R2: divider 0 runs as divider 1
        poke(1'b0, 32'h4000_0000);
        phy_here = 1; phy_resp = 16'h0001;
        poke(1'b1, 32'h8230_0000);
        wait_done();
        peek(1'b1, v); chk("R2 div0 read result", v, 32'h2230_0001);

        // R10: disable during a frame, frame still completes
        poke(1'b0, 32'h4000_0002);
        poke(1'b1, 32'hC083_8001);
        idle(20);
        poke(1'b0, 32'h0000_0002);
        wait_done();
        peek(1'b1, v); chk("R10 frame finished", v, 32'h4083_8001);
        begin
            int hi;
            hi = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); #6; if (mdc) hi++; end
            chk("R10 mdc parked", 32'(hi), 32'h0);
        end

        // R10: start flag pending while disabled
        phy_resp = 16'h7E81;
        poke(1'b1, 32'h8021_0000);
        idle(40);
        peek(1'b0, v); chk("R11 idle while pending", v, 32'h8000_0002);
        peek(1'b1, v); chk("R10 go pending", v, 32'h8021_0000);
        chk("R11 released between frames", {30'b0, mdio_oe, mdio_o}, 32'h1);
        poke(1'b0, 32'h4000_0002);
        wait_done();
        peek(1'b1, v); chk("R10 launched after enable", v, 32'h2021_7E81);

        idle(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule